// File: doc/BRIEF.md
# PCI-to-ISA Bridge Configuration Space

This block is the function-0 configuration register file of a PCI-to-ISA southbridge. A host-side agent reaches it through a byte-wide request stream that carries an 8-bit register address. Read data comes back on a separate response stream. The bus protocol that produces these requests sits outside the block.

Besides storing bytes, the block turns some of them into live side-band controls:

- four PCI interrupt routing codes, each with an enable;
- a one-cycle interrupt request on IRQ10 or IRQ15;
- a one-cycle software SMI request, which is held back while the CPU is in system management mode;
- an ISA clock divisor select;
- a host-to-PCI clock ratio select.

The identification and class bytes are fixed, apart from a device ID parameter. One status byte clears only when a 1 is written to it. Addresses the block does not implement ignore writes and read as zero.

Back-pressure works as follows. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A read's data appears on `rsp_rdata` with `rsp_valid` one cycle after acceptance. That data holds steady until the edge where `rsp_ready` is high. `req_ready` is low only while a response waits unconsumed, so no request of either kind is accepted during that time. Writes produce no response.

Top module: `isa_bridge_cfg`

## Requirements
- R1: Identification reads are fixed and ignore writes. 0x00=0x60, 0x01=0x10, 0x02 is DEVICE_ID[7:0] and 0x03 is DEVICE_ID[15:8] (default 0x86 and 0x88). 0x08=0x0E, 0x09=0x00, 0x0A=0x01 and 0x0B=0x06.
- R2: After reset, these registers read as follows: 0x04=0x0F, 0x07=0x02, 0x40=0x01, 0x41=0x06, 0x42=0x08, 0x43=0x9A, 0x44=0xBC, 0x45=0x04, 0x47=0x40, 0x50=0x01, 0x51=0x03 and 0xA8=0x20. Every other implemented register reads 0x00.
- R3: The following registers read back exactly the last byte written: 0x04, 0x05, 0x0C, 0x0D, 0x40-0x47, 0x50-0x56, 0x70-0x76, 0x80, 0x81, 0x90-0x92 and 0xA0-0xA8.
- R4: Writing 0x07 clears each stored bit where the data has a 1 and the mask 0xF9 has a 1. A write never sets a bit, so with the reset value 0x02 the byte keeps reading 0x02.
- R5: Writes to unimplemented addresses (for example 0x48, 0x60, 0xB0, 0xFF) have no effect, and reads from them return 0x00.
- R6: The routing outputs are packed four bits per lane. Lane 0 (INTA) is `route_code[3:0]`, lane 1 (INTB) is `[7:4]`, lane 2 (INTC) is `[11:8]` and lane 3 (INTD) is `[15:12]`.
  - Register 0x43 routes lanes 0 and 1: its high nibble goes to lane 0 and its low nibble to lane 1.
  - Register 0x44 routes lanes 2 and 3: its high nibble goes to lane 2 and its low nibble to lane 3.
  - A nibble of 0 disables the lane (`route_en` bit 0, code 0). Any other value is the IRQ number with `route_en` set.
  - The outputs change in the cycle after the write is accepted.
- R7: After reset all four lanes are disabled, even though 0x43 and 0x44 hold non-zero bytes. A pair turns on only once its own register has been written.
- R8: A write to 0x46 with bit 6 set drives a one-cycle pulse on `irq_req`. The pulse is bit 15 when data bit 7 is 1 and bit 10 when it is 0, and it falls in the cycle after acceptance. A write with bit 6 clear gives no pulse.
- R9: A write to 0xA3 with bits 7 and 6 both 1 gives a one-cycle `smi_req` pulse in the cycle after acceptance. This happens only if `smm_active` was low at the accepting edge; any other data, or `smm_active` high, gives no pulse.
- R10: `isa_div` is 3 when bit 1 of register 0x56 is 0 and 2 when it is 1. Other bits of 0x56 have no effect.
- R11: `host_pci_1to1` follows bit 0 of register 0xA4 (1 means 1:1, 0 means 1:2).
- R12: A read's data appears with `rsp_valid` one cycle after acceptance. While `rsp_valid` is high and `rsp_ready` is low, the data is held, `req_ready` is low and no request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_rdata | output | 8 | Read data |
| smm_active | input | 1 | CPU is in system management mode |
| route_code | output | 16 | Four 4-bit IRQ routing codes |
| route_en | output | 4 | Per-lane routing enable |
| irq_req | output | 16 | One-hot interrupt request pulse |
| smi_req | output | 1 | Software SMI request pulse |
| isa_div | output | 2 | ISA clock divisor from the PCI clock (2 or 3) |
| host_pci_1to1 | output | 1 | Host-to-PCI clock ratio is 1:1 |

## Verification
Two functions can fall in the same cycle, and both are provoked deliberately.

The first is a stalled read response meeting a queued write. The bench holds `rsp_ready` low after a read while a write to 0x41 waits on the request side. It checks that `req_ready` stays low and the response holds over several cycles. Then it releases `rsp_ready`, so the response drains and the write is accepted on the same edge. A later read-back shows the write landed exactly once.

The second is a software SMI write arriving in the cycle `smm_active` rises. The bench expects no pulse there, but expects the stored 0xA3 value to update anyway.

// File: rtl/isa_cfg_pkg.sv
package isa_cfg_pkg;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RO   = 2'd1,
    ACC_RW   = 2'd2,
    ACC_W1C  = 2'd3
  } acc_e;

  localparam logic [7:0] A_STAT     = 8'h07;
  localparam logic [7:0] A_ROUTE_AB = 8'h43;
  localparam logic [7:0] A_ROUTE_CD = 8'h44;
  localparam logic [7:0] A_IRQ_GEN  = 8'h46;
  localparam logic [7:0] A_ISA_CLK  = 8'h56;
  localparam logic [7:0] A_SMI_CTL  = 8'hA3;
  localparam logic [7:0] A_HOST_CLK = 8'hA4;
  localparam logic [7:0] W1C_MASK   = 8'hF9;

  function automatic acc_e acc_kind(input logic [7:0] a);
    if (a <= 8'h03 || (a >= 8'h08 && a <= 8'h0B)) return ACC_RO;
    if (a == A_STAT) return ACC_W1C;
    if (a == 8'h04 || a == 8'h05 || a == 8'h0C || a == 8'h0D) return ACC_RW;
    if (a >= 8'h40 && a <= 8'h47) return ACC_RW;
    if (a >= 8'h50 && a <= 8'h56) return ACC_RW;
    if (a >= 8'h70 && a <= 8'h76) return ACC_RW;
    if (a == 8'h80 || a == 8'h81) return ACC_RW;
    if (a >= 8'h90 && a <= 8'h92) return ACC_RW;
    if (a >= 8'hA0 && a <= 8'hA8) return ACC_RW;
    return ACC_NONE;
  endfunction

  function automatic logic [7:0] init_val(input logic [7:0] a);
    case (a)
      8'h04: return 8'h0F;
      8'h07: return 8'h02;
      8'h40: return 8'h01;
      8'h41: return 8'h06;
      8'h42: return 8'h08;
      8'h43: return 8'h9A;
      8'h44: return 8'hBC;
      8'h45: return 8'h04;
      8'h47: return 8'h40;
      8'h50: return 8'h01;
      8'h51: return 8'h03;
      8'hA8: return 8'h20;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] fixed_val(input logic [7:0] a, input logic [15:0] dev);
    case (a)
      8'h00: return 8'h60;
      8'h01: return 8'h10;
      8'h02: return dev[7:0];
      8'h03: return dev[15:8];
      8'h08: return 8'h0E;
      8'h0A: return 8'h01;
      8'h0B: return 8'h06;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/isa_cfg_regfile.sv
module isa_cfg_regfile
  import isa_cfg_pkg::*;
#(
  parameter logic [15:0] DEVICE_ID = 16'h8886,
  parameter int          AW        = 8,
  parameter int          DW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] route_ab,
  output logic [DW-1:0] route_cd,
  output logic [DW-1:0] isa_clk,
  output logic [DW-1:0] host_clk
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= init_val(8'(i));
    end else if (wr_en) begin
      case (acc_kind(wr_addr))
        ACC_RW:  mem[wr_addr] <= wr_data;
        ACC_W1C: mem[wr_addr] <= mem[wr_addr] & ~(wr_data & W1C_MASK);
        default: ;
      endcase
    end
  end

  always_comb begin
    case (acc_kind(rd_addr))
      ACC_RO:           rd_data = fixed_val(rd_addr, DEVICE_ID);
      ACC_RW, ACC_W1C:  rd_data = mem[rd_addr];
      default:          rd_data = '0;
    endcase
  end

  assign route_ab = mem[A_ROUTE_AB];
  assign route_cd = mem[A_ROUTE_CD];
  assign isa_clk  = mem[A_ISA_CLK];
  assign host_clk = mem[A_HOST_CLK];

  logic [DW-1:0] stat_q;
  assign stat_q = mem[A_STAT];

  AST_STAT_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_STAT) |=> ((stat_q & ~$past(stat_q)) == '0)); // R4

endmodule

// File: rtl/isa_cfg_route.sv
module isa_cfg_route
  import isa_cfg_pkg::*;
#(
  parameter int LANES = 4,
  parameter int NIB_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [7:0]             wr_addr,
  input  logic [7:0]             route_ab,
  input  logic [7:0]             route_cd,
  output logic [LANES*NIB_W-1:0] route_code,
  output logic [LANES-1:0]       route_en
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic [7:0] SRC_ADDR = (l < 2) ? A_ROUTE_AB : A_ROUTE_CD;
    logic             live_q;
    logic [7:0]       src;
    logic [NIB_W-1:0] nib;

    always_ff @(posedge clk) begin
      if (!rst_n)                             live_q <= 1'b0;
      else if (wr_en && wr_addr == SRC_ADDR)  live_q <= 1'b1;
    end

    assign src = (l < 2) ? route_ab : route_cd;
    assign nib = (l % 2 == 0) ? src[7:4] : src[3:0];
    assign route_en[l] = live_q && (nib != '0);
    assign route_code[l*NIB_W +: NIB_W] = route_en[l] ? nib : '0;
  end

endmodule

// File: rtl/isa_cfg_event.sv
module isa_cfg_event
  import isa_cfg_pkg::*;
#(
  parameter int IRQ_W  = 16,
  parameter int IRQ_HI = 15,
  parameter int IRQ_LO = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             smm_active,
  output logic [IRQ_W-1:0] irq_req,
  output logic             smi_req
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_req <= '0;
      smi_req <= 1'b0;
    end else begin
      irq_req <= '0;
      smi_req <= 1'b0;
      if (wr_en && wr_addr == A_IRQ_GEN && wr_data[6])
        irq_req <= wr_data[7] ? (IRQ_W'(1) << IRQ_HI) : (IRQ_W'(1) << IRQ_LO);
      if (wr_en && wr_addr == A_SMI_CTL && wr_data[7:6] == 2'b11 && !smm_active)
        smi_req <= 1'b1;
    end
  end

  AST_IRQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_req)); // R8

  AST_SMI_OUTSIDE_SMM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smi_req) |-> !$past(smm_active)); // R9

endmodule

// File: rtl/isa_bridge_cfg.sv
module isa_bridge_cfg
  import isa_cfg_pkg::*;
#(
  parameter logic [15:0] DEVICE_ID = 16'h8886
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [7:0]  req_addr,
  input  logic [7:0]  req_wdata,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [7:0]  rsp_rdata,
  input  logic        smm_active,
  output logic [15:0] route_code,
  output logic [3:0]  route_en,
  output logic [15:0] irq_req,
  output logic        smi_req,
  output logic [1:0]  isa_div,
  output logic        host_pci_1to1
);
  logic       accept, wr_stb;
  logic [7:0] rd_data, route_ab, route_cd, isa_clk, host_clk;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_stb    = accept && req_write;

  isa_cfg_regfile #(.DEVICE_ID(DEVICE_ID), .AW(8), .DW(8)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_stb), .wr_addr(req_addr), .wr_data(req_wdata),
    .rd_addr(req_addr), .rd_data(rd_data),
    .route_ab(route_ab), .route_cd(route_cd),
    .isa_clk(isa_clk), .host_clk(host_clk)
  );

  isa_cfg_route #(.LANES(4), .NIB_W(4)) u_route (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_stb), .wr_addr(req_addr),
    .route_ab(route_ab), .route_cd(route_cd),
    .route_code(route_code), .route_en(route_en)
  );

  isa_cfg_event #(.IRQ_W(16), .IRQ_HI(15), .IRQ_LO(10)) u_event (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_stb), .wr_addr(req_addr), .wr_data(req_wdata),
    .smm_active(smm_active),
    .irq_req(irq_req), .smi_req(smi_req)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign isa_div       = isa_clk[1] ? 2'd2 : 2'd3;
  assign host_pci_1to1 = host_clk[0];

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata))); // R12

endmodule

// File: tb/sim_isa_bridge_cfg.sv
module sim_isa_bridge_cfg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0, req_wdata = '0;
  logic        rsp_ready = 1'b1, smm_active = 1'b0;
  logic        req_ready, rsp_valid, smi_req, host_pci_1to1;
  logic [7:0]  rsp_rdata;
  logic [15:0] route_code, irq_req;
  logic [3:0]  route_en;
  logic [1:0]  isa_div;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [15:0] cap_irq;
  logic        cap_smi;

  always #10 clk = ~clk;

  isa_bridge_cfg u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .smm_active(smm_active), .route_code(route_code), .route_en(route_en),
    .irq_req(irq_req), .smi_req(smi_req), .isa_div(isa_div),
    .host_pci_1to1(host_pci_1to1)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // issue one request; returns at the falling edge after it was accepted
  task automatic issue(input logic wr, input logic [7:0] a, input logic [7:0] d);
    logic acc;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    forever begin
      acc = req_ready;
      @(negedge clk);
      if (acc) break;
      #2;
    end
    cap_irq = irq_req;
    cap_smi = smi_req;
    #2;
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    issue(1'b1, a, d);
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    issue(1'b0, a, 8'h00);
  endtask

  // scoreboard monitor: samples just before each rising edge
  always begin
    @(negedge clk);
    #8;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) check("R12 unexpected response", 32'(rsp_rdata), 32'hFFFF);
      else check(tag_q.pop_front(), 32'(rsp_rdata), 32'(exp_q.pop_front()));
    end
  end

  function automatic logic [7:0] bench_reset(input logic [7:0] a);
    case (a)
      8'h04: return 8'h0F; 8'h07: return 8'h02; 8'h40: return 8'h01;
      8'h41: return 8'h06; 8'h42: return 8'h08; 8'h43: return 8'h9A;
      8'h44: return 8'hBC; 8'h45: return 8'h04; 8'h47: return 8'h40;
      8'h50: return 8'h01; 8'h51: return 8'h03; 8'hA8: return 8'h20;
      default: return 8'h00;
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rw_list [12];
    rw_list = '{8'h05, 8'h0C, 8'h0D, 8'h42, 8'h45, 8'h53, 8'h70, 8'h76, 8'h81, 8'h92, 8'hA0, 8'hA8};
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk); #2;

    // R7 reset state of side-band outputs
    check("R7 route_en after reset", 32'(route_en), 0);
    check("R7 route_code after reset", 32'(route_code), 0);
    check("R10 isa_div after reset", 32'(isa_div), 3);
    check("R11 host ratio after reset", 32'(host_pci_1to1), 0);
    check("R8 irq idle after reset", 32'(irq_req), 0);

    // R1 identification
    rd(8'h00, 8'h60, "R1 id 00"); rd(8'h01, 8'h10, "R1 id 01");
    rd(8'h02, 8'h86, "R1 id 02"); rd(8'h03, 8'h88, "R1 id 03");
    rd(8'h08, 8'h0E, "R1 rev");   rd(8'h09, 8'h00, "R1 class 09");
    rd(8'h0A, 8'h01, "R1 class 0A"); rd(8'h0B, 8'h06, "R1 class 0B");
    wr(8'h00, 8'hFF); wr(8'h0B, 8'h00);
    rd(8'h00, 8'h60, "R1 id write ignored"); rd(8'h0B, 8'h06, "R1 class write ignored");

    // R2 reset values
    foreach (rw_list[i]) rd(rw_list[i], bench_reset(rw_list[i]), "R2 reset value");
    rd(8'h04, 8'h0F, "R2 reset 04"); rd(8'h43, 8'h9A, "R2 reset 43");
    rd(8'h44, 8'hBC, "R2 reset 44"); rd(8'h47, 8'h40, "R2 reset 47");
    rd(8'h51, 8'h03, "R2 reset 51"); rd(8'h07, 8'h02, "R2 reset 07");

    // R3 read/write storage
    foreach (rw_list[i]) wr(rw_list[i], rw_list[i] ^ 8'hA5);
    foreach (rw_list[i]) rd(rw_list[i], rw_list[i] ^ 8'hA5, "R3 readback");

    // R4 status clear-on-one with mask
    wr(8'h07, 8'hFF);
    rd(8'h07, 8'h02, "R4 masked bit survives");

    // R5 unimplemented addresses
    wr(8'h48, 8'hFF); wr(8'h60, 8'h3C); wr(8'hB0, 8'h11); wr(8'hFF, 8'h77);
    rd(8'h48, 8'h00, "R5 read 48"); rd(8'h60, 8'h00, "R5 read 60");
    rd(8'hB0, 8'h00, "R5 read B0"); rd(8'hFF, 8'h00, "R5 read FF");

    // R6 routing
    wr(8'h43, 8'h5B);
    check("R6 en after 43", 32'(route_en), 32'b0011);
    check("R6 code after 43", 32'(route_code), 32'h00B5);
    wr(8'h44, 8'h0E);
    check("R6 en after 44 zero nibble", 32'(route_en), 32'b1011);
    check("R6 code after 44", 32'(route_code), 32'hE0B5);
    wr(8'h43, 8'h70);
    check("R6 en lane1 disabled", 32'(route_en), 32'b1001);
    check("R6 code lane1 disabled", 32'(route_code), 32'hE007);

    // R8 interrupt request pulse
    wr(8'h46, 8'hC0);
    check("R8 irq15 pulse", 32'(cap_irq), 32'h8000);
    @(negedge clk);
    check("R8 pulse one cycle", 32'(irq_req), 0);
    #2 wr(8'h46, 8'h40);
    check("R8 irq10 pulse", 32'(cap_irq), 32'h0400);
    wr(8'h46, 8'h80);
    check("R8 no pulse bit6 clear", 32'(cap_irq), 0);
    rd(8'h46, 8'h80, "R3 46 stored");

    // R9 software SMI
    wr(8'hA3, 8'hC0);
    check("R9 smi pulse", 32'(cap_smi), 1);
    @(negedge clk);
    check("R9 smi one cycle", 32'(smi_req), 0);
    #2 wr(8'hA3, 8'h80);
    check("R9 smi needs both bits", 32'(cap_smi), 0);
    smm_active = 1'b1;                         // rises with the write
    wr(8'hA3, 8'hC0);
    check("R9 smi suppressed in SMM", 32'(cap_smi), 0);
    rd(8'hA3, 8'hC0, "R9 A3 stored while in SMM");
    smm_active = 1'b0;

    // R10 / R11 clock selects
    wr(8'h56, 8'h02);
    check("R10 div 2", 32'(isa_div), 2);
    wr(8'h56, 8'hFD);
    check("R10 div 3 other bits ignored", 32'(isa_div), 3);
    wr(8'hA4, 8'h01);
    check("R11 ratio 1:1", 32'(host_pci_1to1), 1);
    wr(8'hA4, 8'hFE);
    check("R11 ratio 1:2", 32'(host_pci_1to1), 0);

    // R12 back-pressure collision
    rsp_ready = 1'b0;
    rd(8'h40, 8'h01, "R12 held response");
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h41; req_wdata = 8'h55;
    check("R12 ready low while stalled", 32'(req_ready), 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R12 response held", 32'({rsp_valid, req_ready, rsp_rdata}), 32'h201);
    end
    #2 rsp_ready = 1'b1;
    @(negedge clk);
    #2 req_valid = 1'b0;
    check("R12 no response for write", 32'(rsp_valid), 0);
    rd(8'h41, 8'h55, "R12 write landed once");

    wait (exp_q.size() == 0);
    repeat (2) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule